// File: doc/BRIEF.md
# Prescaled Timer with Edge-Aligned PWM Channels

This block is a single up-counting timer that drives six pulse-width outputs from one shared count. Software programs it through a write-only register port: a control register that starts or stops the count and picks a power-of-two clock divider, a 16-bit count register, a 16-bit period limit and, for every channel, a two-bit mode field and a 16-bit threshold.

While running, the count advances once per divided clock tick. It climbs to the period limit and then returns to zero, so one period lasts limit + 1 ticks. A channel placed in pulse mode drives its output high from the return to zero until the count reaches that channel's threshold. Thresholds written during a run are held back and applied at the next return to zero, so a period in progress is never cut short. Intended use: stop the count, clear it, load the limit, modes and thresholds, then start it. To silence an output, stop the count, clear it and write a threshold of zero.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset every register holds zero, so the count reads 0 and all six outputs are low.
- R2: With divider code n (control bits [2:0]) the count advances once every 2^n clock cycles. The first advance comes on the 2^n-th rising edge after the edge that wrote the start value.
- R3: Control bits [4:3] equal to 01 run the count. Any other value stops it, and the count then holds its value.
- R4: When the count equals the period limit, the next advance returns it to 0. A limit of 0 keeps the count at 0.
- R5: Any write to the count register clears the count on that edge. The clear wins over an advance on the same edge.
- R6: A channel with mode bits [1:0] = 11 drives its output high exactly while the count is below its active threshold.
- R7: An active threshold above the period limit gives an output that stays high. A threshold of 0 gives an output that stays low.
- R8: While the count runs, a new threshold becomes active at the next return to zero. While stopped, it becomes active one cycle after the write.
- R9: A channel whose mode bits are anything other than 11 holds its output low.
- R10: Write addresses: 0 control, 1 count, 2 period limit, 4+c mode of channel c, 10+c threshold of channel c (c = 0..5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 16 | Register write data |
| countOut | output | 16 | Current count value |
| pwmOut | output | 6 | Channel outputs |

## Verification
The bench sweeps every divider code from 0 to 3 against period limits of 0, 1, 3 and 6. It uses thresholds of zero, one, the limit and the limit plus one. A divider that ticks one cycle early or late, or a wrap at limit−1 or limit+1, shows up as a count mismatch. An off-by-one threshold compare shows up as a wrong pulse width. A threshold changed in mid-period must keep the old width until the wrap; a design that applies it at once gives a short period. The bench also writes the count while it is advancing, where a design that lets the advance win would read 1 instead of 0.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int NUM_CH    = 6;
  localparam int ADDR_W    = 4;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CNT  = 1;
  localparam int ADDR_MOD  = 2;
  localparam int MODE_BASE = 4;
  localparam int CMP_BASE  = MODE_BASE + NUM_CH;
  localparam logic [1:0] RUN_CODE  = 2'b01;
  localparam logic [1:0] PULSE_MODE = 2'b11;

  typedef struct packed {
    logic              tick;
    logic              stopped;
    logic              cntClr;
    logic              modWr;
    logic [NUM_CH-1:0] modeWr;
    logic [NUM_CH-1:0] cmpWr;
  } strobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PS_W+1:0]   ctrlData,
  output strobe_t           strb
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [PS_W-1:0]  psCode;
  logic [1:0]       clkMode;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;
  logic             running;

  assign running = (clkMode == RUN_CODE);
  assign divMask = {DIV_W{1'b1}} >> (PS_W'(DIV_W) - psCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCode  <= '0;
      clkMode <= '0;
      divCnt  <= '0;
    end else begin
      if (wrEn && wrAddr == ADDR_W'(ADDR_CTRL)) begin
        psCode  <= ctrlData[PS_W-1:0];
        clkMode <= ctrlData[PS_W+1:PS_W];
      end
      if (running) divCnt <= divCnt + 1'b1;
      else         divCnt <= '0;
    end
  end

  always_comb begin
    strb.tick    = running && ((divCnt & divMask) == divMask);
    strb.stopped = !running;
    strb.cntClr  = wrEn && wrAddr == ADDR_W'(ADDR_CNT);
    strb.modWr   = wrEn && wrAddr == ADDR_W'(ADDR_MOD);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign strb.modeWr[c] = wrEn && wrAddr == ADDR_W'(MODE_BASE + c);
    assign strb.cmpWr[c]  = wrEn && wrAddr == ADDR_W'(CMP_BASE + c);
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  countOut,
  output logic [CNT_W-1:0]  modQ,
  output logic [NUM_CH-1:0] pwmOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] modReg;
  logic             wrap;

  assign wrap     = strb.tick && (cnt >= modReg);
  assign countOut = cnt;
  assign modQ     = modReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      modReg <= '0;
    end else begin
      if (strb.modWr) modReg <= wrData;
      if (strb.cntClr)    cnt <= '0;
      else if (wrap)      cnt <= '0;
      else if (strb.tick) cnt <= cnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [1:0]       modeReg;
    logic [CNT_W-1:0] cmpBuf;
    logic [CNT_W-1:0] cmpAct;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeReg <= '0;
        cmpBuf  <= '0;
        cmpAct  <= '0;
      end else begin
        if (strb.modeWr[c]) modeReg <= wrData[1:0];
        if (strb.cmpWr[c])  cmpBuf  <= wrData;
        if (strb.stopped || wrap) cmpAct <= cmpBuf;
      end
    end

    assign pwmOut[c] = (modeReg == PULSE_MODE) && (cnt < cmpAct);
  end
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  countOut,
  output logic [NUM_CH-1:0] pwmOut
);
  strobe_t          strb;
  logic [CNT_W-1:0] modQ;

  pwm_ctrl #(.PS_W(PS_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .ctrlData (wrData[PS_W+1:0]),
    .strb     (strb)
  );

  pwm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .countOut (countOut),
    .modQ     (modQ),
    .pwmOut   (pwmOut)
  );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CNT_W-1:0]  countOut,
  input logic [CNT_W-1:0]  modQ,
  input strobe_t           strb
);
  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(ADDR_CNT)) |=> countOut == '0);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.cntClr) |=> $stable(countOut));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.cntClr && countOut == modQ) |=> countOut == '0);

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.cntClr && countOut < modQ)
      |=> countOut == CNT_W'($past(countOut) + 1'b1));

  // R10
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cntClr, strb.modWr, strb.modeWr, strb.cmpWr}));
endmodule

bind pwm_timer_top pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .countOut (countOut),
  .modQ     (modQ),
  .strb     (strb)
);

// File: tb/tb_pwm_timer_top.sv
module tb_pwm_timer_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] countOut;
  logic [5:0]  pwmOut;

  int testCount = 0;
  int failCount = 0;
  bit doneFlag = 0;

  pwm_timer_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .countOut(countOut), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // R10 address map: 0 ctrl, 1 count, 2 limit, 4+c mode, 10+c threshold
  task automatic configure(input int ps, input int lim, input int cv[6], input int md[6]);
    wr(0, 0);
    wr(1, 0);
    wr(2, lim);
    for (int c = 0; c < 6; c++) begin
      wr(4 + c, md[c]);
      wr(10 + c, cv[c]);
    end
    wr(0, (1 << 3) | ps);
  endtask

  function automatic int expPwm(input int cnt, input int cv[6], input int md[6]);
    int v = 0;
    for (int c = 0; c < 6; c++)
      if (md[c] == 3 && cnt < cv[c]) v |= (1 << c);
    return v;
  endfunction

  initial begin
    int cv[6];
    int md[6];
    int lims[4] = '{0, 1, 3, 6};
    int held;

    repeat (3) @(negedge clk);
    // R1
    check("R1 count", int'(countOut), 0);
    check("R1 pwm", int'(pwmOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 count after release", int'(countOut), 0);

    // R2 R4 R6 R7 R9 sweep
    for (int ps = 0; ps < 4; ps++) begin
      for (int li = 0; li < 4; li++) begin
        int lim = lims[li];
        int nCyc = (lim + 1) * (1 << ps) * 2 + 2;
        cv = '{0, 1, 2, lim, lim + 1, 3};
        md = '{3, 3, 3, 3, 3, 2};
        configure(ps, lim, cv, md);
        check("R2 count at start", int'(countOut), 0);
        for (int k = 1; k <= nCyc; k++) begin
          int ec;
          @(negedge clk);
          ec = (k >> ps) % (lim + 1);
          check("R2/R4 count", int'(countOut), ec);
          check("R6/R7/R9 pwm", int'(pwmOut), expPwm(ec, cv, md));
        end
      end
    end

    // R9: other non-pulse mode codes
    cv = '{0, 5, 5, 5, 5, 5};
    md = '{3, 0, 1, 2, 3, 1};
    configure(0, 9, cv, md);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check("R9 pwm modes", int'(pwmOut), expPwm(k % 10, cv, md));
    end

    // R5: count write while advancing
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd1; wrData = 16'hBEEF;
    @(negedge clk);
    wrEn = 1'b0;
    check("R5 cleared despite tick", int'(countOut), 0);
    @(negedge clk);
    check("R5 resumes", int'(countOut), 1);

    // R3: stop with code 10 and code 00
    wr(0, (2 << 3));
    held = int'(countOut);
    repeat (6) @(negedge clk);
    check("R3 hold code 10", int'(countOut), held);
    wr(0, 0);
    repeat (4) @(negedge clk);
    check("R3 hold code 00", int'(countOut), held);

    // R8: threshold change mid-run applies at wrap
    cv = '{5, 0, 0, 0, 0, 0};
    md = '{3, 0, 0, 0, 0, 0};
    configure(0, 9, cv, md);
    @(negedge clk);
    @(negedge clk);
    check("R8 count before write", int'(countOut), 2);
    wrEn = 1'b1; wrAddr = 4'd10; wrData = 16'd8;
    for (int k = 3; k <= 25; k++) begin
      int ec;
      int act;
      @(negedge clk);
      wrEn = 1'b0;
      ec = k % 10;
      act = (k >= 10) ? 8 : 5;
      check("R8 count", int'(countOut), ec);
      check("R8 pwm0 shadow", int'(pwmOut[0]), (ec < act) ? 1 : 0);
    end

    // R8/R7: stop procedure silences the output
    wr(0, 0);
    wr(1, 0);
    wr(10, 0);
    @(negedge clk);
    check("R8 stopped count", int'(countOut), 0);
    check("R7 stopped zero threshold", int'(pwmOut), 0);

    if (!doneFlag) begin
      doneFlag = 1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      testCount++;
      failCount++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule